// File: doc/BRIEF.md
# Quarter-Wave Folding Step Sequencer

This block steps through the taps of a sine-weighted stepped DAC. The resistor network holds the taps for a single quarter of a sine wave. The sequencer walks the tap index up through that set and then back down. It then repeats the same walk with the polarity bit set, so that an external inverter produces the negative half. Each tap is therefore used four times per output period, and the waveform is symmetric in both time and sign by construction.

A free-running phase counter advances by one step on each clock where `step_en` is high. With `IDX_W` index bits the output period is 4·2^`IDX_W` steps. The default of 4 index bits gives 16 taps and 64 steps. The reduced form with 3 bits gives 8 taps and 32 steps. The tap index is the low `IDX_W` counter bits XORed with counter bit `IDX_W`, and the counter MSB is the polarity. The `ONEHOT_OUT` parameter sets the select output format:
- When it is 1, the output is a one-hot vector that enables exactly one tap switch.
- When it is 0, the output is the binary index, for an external analog multiplexer.

A one-clock strobe marks the start of every new period.

Top module: `quad_fold_seq`

## Requirements
- R1: While `rst_n` is low, the phase is 0. The index is then 0 (one-hot code is bit 0 set), `negate` is 0 and `cycle_start` is 0.
- R2: Each clock with `step_en` high advances the phase by one, modulo 4·2^IDX_W. With `step_en` low, `tap_sel` and `negate` hold their values.
- R3: The index for phase p is (p mod 2^IDX_W), with every bit inverted when bit IDX_W of p is 1. It climbs 0..2^IDX_W−1 and then falls back to 0, twice per period, so consecutive steps never differ by more than one.
- R4: `negate` is 0 for phases 0..2·2^IDX_W−1 and 1 for the remaining half. It changes only where the index is 0.
- R5: With ONEHOT_OUT=1, `tap_sel` is 2^IDX_W bits wide and has exactly one bit set: bit i for index i.
- R6: With ONEHOT_OUT=0, `tap_sel` is IDX_W bits wide and carries the index as an unsigned binary value.
- R7: Over any one full period starting at phase 0, each index value occurs exactly four times.
- R8: `cycle_start` is 1 for exactly the one clock that follows an enabled step from the last phase to phase 0. It is 0 at all other times, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the phase by one step on this clock |
| tap_sel | output | ONEHOT_OUT ? 2^IDX_W : IDX_W | One-hot tap enable or binary tap index |
| negate | output | 1 | Polarity select for the analog inverter (1 = negative half) |
| cycle_start | output | 1 | One-clock pulse at the start of each period |

## Verification
The assertions check the following on every cycle:
- the select is one-hot;
- the outputs hold while stepping is disabled;
- the index moves by at most one per step;
- polarity changes only at index 0;
- the strobe coincides with phase 0 and positive polarity, and never lasts two clocks.

Only the bench's scenarios can show the rest:
- the exact up-down order of the index;
- the four-fold use of each tap per period;
- that the strobe appears only after a real wrap and not after reset.

The bench checks these against a phase model under random enable patterns, for both the 16-tap one-hot form and the 8-tap binary form.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;

  // Index for a given phase: low bits mirrored in odd quarters.
  function automatic logic [7:0] fold_of(input logic [9:0] phase, input int idx_w);
    logic [7:0] low;
    low = phase[7:0] & ((8'd1 << idx_w) - 8'd1);
    if (phase[idx_w]) low = ~low & ((8'd1 << idx_w) - 8'd1);
    return low;
  endfunction
endpackage

// File: rtl/qfs_phase_ctr.sv
module qfs_phase_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] phase_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] phase_q, phase_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    phase_d = phase_q;
    wrap_d  = 1'b0;
    if (en) begin
      phase_d = phase_q + 1'b1;
      wrap_d  = (phase_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wrap_q  <= wrap_d;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/qfs_fold.sv
module qfs_fold
  import qfs_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W+1:0] phase_i,
  output logic [IDX_W-1:0] idx_o,
  output pol_e             pol_o
);
  assign idx_o = phase_i[IDX_W-1:0] ^ {IDX_W{phase_i[IDX_W]}};
  assign pol_o = pol_e'(phase_i[IDX_W+1]);
endmodule

// File: rtl/qfs_tap_out.sv
module qfs_tap_out #(
  parameter int IDX_W      = 4,
  parameter bit ONEHOT_OUT = 1'b1,
  localparam int TAPS      = 1 << IDX_W,
  localparam int SEL_W     = ONEHOT_OUT ? TAPS : IDX_W
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [SEL_W-1:0] sel_o
);
  generate
    if (ONEHOT_OUT) begin : g_onehot
      for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign sel_o[t] = (idx_i == IDX_W'(t));
      end
    end else begin : g_binary
      assign sel_o = idx_i;
    end
  endgenerate
endmodule

// File: rtl/quad_fold_seq.sv
module quad_fold_seq
  import qfs_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter bit ONEHOT_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic [(ONEHOT_OUT ? (1 << IDX_W) : IDX_W)-1:0] tap_sel,
  output logic negate,
  output logic cycle_start
);
  localparam int CNT_W = IDX_W + 2;

  logic [CNT_W-1:0] phase;
  logic [IDX_W-1:0] idx;
  pol_e             pol;

  qfs_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (step_en),
    .phase_o (phase),
    .wrap_o  (cycle_start)
  );

  qfs_fold #(.IDX_W(IDX_W)) u_fold (
    .phase_i (phase),
    .idx_o   (idx),
    .pol_o   (pol)
  );

  qfs_tap_out #(.IDX_W(IDX_W), .ONEHOT_OUT(ONEHOT_OUT)) u_out (
    .idx_i (idx),
    .sel_o (tap_sel)
  );

  assign negate = (pol == POL_NEG);
endmodule

// File: rtl/qfs_checker.sv
module qfs_checker #(
  parameter int IDX_W      = 4,
  parameter bit ONEHOT_OUT = 1'b1,
  localparam int SEL_W     = ONEHOT_OUT ? (1 << IDX_W) : IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic [SEL_W-1:0] tap_sel,
  input logic             negate,
  input logic             cycle_start
);
  int obs_idx;

  always_comb begin
    obs_idx = 0;
    if (ONEHOT_OUT) begin
      for (int t = 0; t < SEL_W; t++)
        if (tap_sel[t]) obs_idx = t;
    end else begin
      obs_idx = int'(tap_sel);
    end
  end

  generate
    if (ONEHOT_OUT) begin : g_oh
      assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);
    end
  endgenerate

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(tap_sel) && $stable(negate)));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((obs_idx - $past(obs_idx)) <= 1) && (($past(obs_idx) - obs_idx) <= 1));

  assert_pol_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(negate) |-> (obs_idx == 0));

  assert_pol_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(negate) |-> (obs_idx == 0));

  assert_strobe_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (obs_idx == 0 && !negate));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);
endmodule

bind quad_fold_seq qfs_checker #(.IDX_W(IDX_W), .ONEHOT_OUT(ONEHOT_OUT)) u_qfs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_en     (step_en),
  .tap_sel     (tap_sel),
  .negate      (negate),
  .cycle_start (cycle_start)
);

// File: tb/tb_quad_fold_seq.sv
`timescale 1ns/1ps
module tb_quad_fold_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic step_en;
  logic [15:0] sel16;
  logic [2:0]  sel8;
  logic neg16, neg8, cs16, cs8;

  int checks = 0;
  int errors = 0;
  int m16 = 0, m8 = 0;
  bit ecs16 = 0, ecs8 = 0;

  always #5 clk = ~clk;

  quad_fold_seq dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .tap_sel(sel16), .negate(neg16), .cycle_start(cs16));

  quad_fold_seq #(.IDX_W(3), .ONEHOT_OUT(1'b0)) dut_bin (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .tap_sel(sel8), .negate(neg8), .cycle_start(cs8));

  function automatic int exp_idx(int p, int w);
    int lo = p % (1 << w);
    if ((p >> w) & 1) lo = (1 << w) - 1 - lo;
    return lo;
  endfunction

  function automatic int dec_oh(logic [15:0] v);
    for (int t = 0; t < 16; t++) if (v == (16'd1 << t)) return t;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(sel16 == (16'd1 << exp_idx(m16, 4)), "R3/R5 onehot sel", int'(sel16),
        1 << exp_idx(m16, 4));
    chk(neg16 == (m16 >= 32), "R4 negate16", neg16, int'(m16 >= 32));
    chk(cs16 == ecs16, "R8 strobe16", cs16, ecs16);
    chk(int'(sel8) == exp_idx(m8, 3), "R6 binary idx", int'(sel8), exp_idx(m8, 3));
    chk(neg8 == (m8 >= 16), "R4 negate8", neg8, int'(m8 >= 16));
    chk(cs8 == ecs8, "R8 strobe8", cs8, ecs8);
  endtask

  task automatic step(bit en);
    step_en = en;
    @(posedge clk);
    ecs16 = en && (m16 == 63);
    ecs8  = en && (m8 == 31);
    if (en) begin
      m16 = (m16 + 1) % 64;
      m8  = (m8 + 1) % 32;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h16[16];
    int h8[8];
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state even with step_en high
    chk(sel16 == 16'd1, "R1 reset sel16", int'(sel16), 1);
    chk(sel8 == 3'd0, "R1 reset sel8", int'(sel8), 0);
    chk(!neg16 && !neg8, "R1 reset negate", int'(neg16 | neg8), 0);
    chk(!cs16 && !cs8, "R1 reset strobe", int'(cs16 | cs8), 0);
    rst_n = 1'b1;

    // R7: one full period from phase 0 with continuous stepping
    foreach (h16[i]) h16[i] = 0;
    foreach (h8[i]) h8[i] = 0;
    for (int s = 0; s < 64; s++) begin
      h16[dec_oh(sel16) & 15]++;
      if (s < 32) h8[sel8]++;
      step(1'b1);
    end
    for (int i = 0; i < 16; i++) chk(h16[i] == 4, "R7 uses per tap 16", h16[i], 4);
    for (int i = 0; i < 8; i++)  chk(h8[i] == 4, "R7 uses per tap 8", h8[i], 4);

    // R2/R8: hold at the wrap point, strobe must be one clock only
    while (m16 != 63) step(1'b1);
    step(1'b1);
    for (int s = 0; s < 4; s++) step(1'b0);
    // R2: idle steps must not move the index
    chk(sel16 == 16'd1, "R2 hold sel16", int'(sel16), 1);

    // Random enable pattern
    for (int s = 0; s < 3000; s++) step(($urandom % 10) < 7);

    // R2: long idle mid-cycle
    for (int s = 0; s < 5; s++) step(1'b1);
    for (int s = 0; s < 6; s++) step(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule